// File: doc/BRIEF.md
# Five-Stage Interlocked Integer Pipeline

This block is a 32-bit in-order integer core with five stages: fetch, decode, execute, memory and writeback. A register sits between each pair of stages. It runs nine instructions: add, sub, and, or, slt, addi, lw, sw and beq. It reads instructions from an asynchronous instruction port and accesses data through a port with an asynchronous read and a synchronous write. A combinational read port lets the surrounding logic or a bench see any architectural register.

The core has no operand forwarding. When an instruction in decode needs a register that an older instruction in execute or memory will still write, decode stalls. During the stall the PC and the fetch/decode register hold their values, and a no-op bubble goes into execute. The register file writes before it reads in the same cycle, so a value that is being written back reaches decode without a stall.

Branches are resolved in decode, where the equality compare and the target adder sit. The instruction after a beq (its delay slot) always executes.

Top module: `core_pipe`

## Requirements
- R1: Instruction encodings are as follows. Every instruction has opcode [31:26], rs [25:21] and rt [20:16].
  - R-type uses opcode 0x00, with rd [15:11], shamt [10:6] and funct [5:0].
  - The R-type funct codes are add 0x20, sub 0x22, and 0x24, or 0x25 and slt 0x2A.
  - I-type places its immediate in [15:0]. The I-type opcodes are addi 0x08, lw 0x23, sw 0x2B and beq 0x04.
- R2: The instructions compute as follows.
  - add, sub, and and or write rs op rt to rd. slt writes 1 to rd if rs < rt as signed numbers, and 0 otherwise.
  - addi writes rs plus the sign-extended immediate to rt.
  - lw and sw use the address rs plus the sign-extended immediate. lw loads into rt and sw stores rt.
  - The final register and memory state matches sequential execution.
- R3: With no hazards the core retires one instruction per cycle. After reset is released, instruction k (k = 0, 1, …) occupies the memory stage in the cycle that follows clock edge k+3, so a store drives its write enable in that cycle.
- R4: An instruction in decode that reads a register still to be written by an instruction in execute or memory stalls. While it stalls, the PC and the decoding instruction are held. The stall lasts 2 cycles when the producer is directly ahead, 1 cycle when one instruction lies between them, and 0 cycles when two or more lie between them. A load followed by its consumer behaves the same way.
- R5: A bubble writes no register and no memory, so the number of stores equals the architectural number of stores.
- R6: Register 0 always reads as zero. Writes to it are discarded. A source or destination of register 0 never causes a stall.
- R7: The hazard check covers only the source fields an instruction actually reads. Those are rs and rt for R-type, sw and beq, and only rs for addi and lw.
- R8: beq compares rs and rt in decode. If they are equal, it redirects fetch to (address of beq + 4) + (sign-extended immediate × 4). The next instruction (the delay slot) always executes. A beq whose operands are still pending stalls, just as in R4.
- R9: While reset is asserted, the fetch address is 0, the data write enable is low and every register reads zero.
- R10: The debug port returns the committed value of the selected register. An instruction's result appears there after clock edge k+5 and not earlier.
- R11: An unrecognised opcode or funct, or an R-type word with nonzero shamt, writes nothing and stores nothing. The all-zero word therefore acts as a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 32 | Fetch byte address (PC) |
| imem_data_i | input | 32 | Instruction word at imem_addr_o, same cycle |
| dmem_addr_o | output | 32 | Data byte address |
| dmem_wdata_o | output | 32 | Store data |
| dmem_we_o | output | 1 | Store enable, written at the next rising edge |
| dmem_rdata_i | input | 32 | Load data at dmem_addr_o, same cycle |
| dbg_sel_i | input | 5 | Register index for the debug view |
| dbg_data_o | output | 32 | Committed value of the selected register |

## Verification
If the interlock is wrong, the first symptom at the ports is timing. A store moves off its expected cycle, or it writes a stale register value within a few cycles of the dependent pair. Because of this, the bench times the edges at which the write enable rises for back-to-back, gapped, load-use and branch-operand dependencies. A bubble that still carries write controls shows up as an extra store. A mistake in the delay slot or the branch target shows up as wrong register contents through the debug port. Randomised programs are compared against a sequential model of final registers, memory and store count.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int ILEN = 32;
  localparam int RAW  = 5;
  localparam int NREG = 1 << RAW;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    mem_to_reg;
    logic    mem_write;
    logic    alu_src;
    logic    reg_dst;
    alu_op_e alu_op;
  } ex_ctrl_t;
endpackage

// File: rtl/core_decoder.sv
module core_decoder
  import core_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [4:0] shamt_i,
  input  logic [5:0] funct_i,
  output ex_ctrl_t   ctrl_o,
  output logic       branch_o,
  output logic       use_rs_o,
  output logic       use_rt_o
);
  logic r_ok;

  always_comb begin
    ctrl_o   = '0;
    branch_o = 1'b0;
    use_rs_o = 1'b0;
    use_rt_o = 1'b0;
    r_ok     = 1'b0;
    case (opcode_i)
      OPC_RTYPE: begin
        if (shamt_i == '0) begin
          r_ok = 1'b1;
          case (funct_i)
            FN_ADD:  ctrl_o.alu_op = ALU_ADD;
            FN_SUB:  ctrl_o.alu_op = ALU_SUB;
            FN_AND:  ctrl_o.alu_op = ALU_AND;
            FN_OR:   ctrl_o.alu_op = ALU_OR;
            FN_SLT:  ctrl_o.alu_op = ALU_SLT;
            default: r_ok = 1'b0;
          endcase
        end
        if (r_ok) begin
          ctrl_o.reg_write = 1'b1;
          ctrl_o.reg_dst   = 1'b1;
          use_rs_o         = 1'b1;
          use_rt_o         = 1'b1;
        end
      end
      OPC_ADDI: begin
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_src   = 1'b1;
        use_rs_o         = 1'b1;
      end
      OPC_LW: begin
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.alu_src    = 1'b1;
        use_rs_o          = 1'b1;
      end
      OPC_SW: begin
        ctrl_o.mem_write = 1'b1;
        ctrl_o.alu_src   = 1'b1;
        use_rs_o         = 1'b1;
        use_rt_o         = 1'b1;
      end
      OPC_BEQ: begin
        branch_o = 1'b1;
        use_rs_o = 1'b1;
        use_rt_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int XLEN = 32,
  parameter int AW   = 5,
  localparam int NR  = 1 << AW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   ra1_i,
  input  logic [AW-1:0]   ra2_i,
  input  logic [AW-1:0]   rdbg_i,
  output logic [XLEN-1:0] rd1_o,
  output logic [XLEN-1:0] rd2_o,
  output logic [XLEN-1:0] rdbg_o,
  input  logic            we_i,
  input  logic [AW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i
);
  logic [XLEN-1:0] rf_q [NR];
  logic            wr_en;

  assign wr_en = we_i && (wa_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NR; i++) rf_q[i] <= '0;
    end else if (wr_en) begin
      rf_q[wa_i] <= wd_i;
    end
  end

  // write-before-read: a same-cycle writeback is visible to decode
  assign rd1_o  = (ra1_i == '0) ? '0 : (wr_en && wa_i == ra1_i) ? wd_i : rf_q[ra1_i];
  assign rd2_o  = (ra2_i == '0) ? '0 : (wr_en && wa_i == ra2_i) ? wd_i : rf_q[ra2_i];
  assign rdbg_o = rf_q[rdbg_i];

  a_r6_zero_port1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra1_i == '0 |-> rd1_o == '0);
  a_r6_zero_port2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra2_i == '0 |-> rd2_o == '0);
  a_r10_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && rdbg_i == wa_i) |=> (rdbg_i != $past(wa_i)) || rdbg_o == $past(wd_i));
endmodule

// File: rtl/core_hazard.sv
module core_hazard #(
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rs_i,
  input  logic [AW-1:0] rt_i,
  input  logic          use_rs_i,
  input  logic          use_rt_i,
  input  logic          ex_we_i,
  input  logic [AW-1:0] ex_dst_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] mem_dst_i,
  output logic          stall_o
);
  logic [AW-1:0] src [2];
  logic [1:0]    used;
  logic [1:0]    hit;

  assign src[0]  = rs_i;
  assign src[1]  = rt_i;
  assign used[0] = use_rs_i;
  assign used[1] = use_rt_i;

  for (genvar g = 0; g < 2; g++) begin : g_src
    assign hit[g] = used[g] && (src[g] != '0) &&
                    ((ex_we_i && ex_dst_i == src[g]) || (mem_we_i && mem_dst_i == src[g]));
  end

  assign stall_o = |hit;

  a_r4_needs_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (ex_we_i || mem_we_i));
  a_r6_zero_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!use_rs_i || rs_i == '0) && (!use_rt_i || rt_i == '0)) |-> !stall_o);
  a_r7_no_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!use_rs_i && !use_rt_i) |-> !stall_o);
endmodule

// File: rtl/core_pipe.sv
module core_pipe
  import core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [ILEN-1:0] imem_data_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  output logic            dmem_we_o,
  input  logic [XLEN-1:0] dmem_rdata_i,
  input  logic [RAW-1:0]  dbg_sel_i,
  output logic [XLEN-1:0] dbg_data_o
);
  // fetch
  logic [XLEN-1:0] pc_q, pc4_f;
  // IF/ID
  logic [ILEN-1:0] instr_d;
  logic [XLEN-1:0] pc4_d;
  // decode
  ex_ctrl_t        ctrl_d;
  logic            branch_d, use_rs_d, use_rt_d, stall_d, br_taken_d;
  logic [RAW-1:0]  rs_d, rt_d, rd_d;
  logic [XLEN-1:0] rs_val_d, rt_val_d, simm_d, br_target_d;
  // ID/EX
  ex_ctrl_t        ctrl_e;
  logic [XLEN-1:0] a_e, b_e, simm_e, src_b_e, alu_y_e;
  logic [RAW-1:0]  rt_e, rd_e, dst_e;
  // EX/MEM
  logic            wr_m, m2r_m, mw_m;
  logic [XLEN-1:0] alu_m, wdata_m;
  logic [RAW-1:0]  dst_m;
  // MEM/WB
  logic            wr_w, m2r_w;
  logic [XLEN-1:0] alu_w, load_w, res_w;
  logic [RAW-1:0]  dst_w;

  // ---------------- IF ----------------
  assign pc4_f       = pc_q + XLEN'(4);
  assign imem_addr_o = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      instr_d <= '0;
      pc4_d   <= '0;
    end else if (!stall_d) begin
      pc_q    <= br_taken_d ? br_target_d : pc4_f;
      instr_d <= imem_data_i;  // delay slot is captured here even on a taken branch
      pc4_d   <= pc4_f;
    end
  end

  // ---------------- ID ----------------
  assign rs_d   = instr_d[25:21];
  assign rt_d   = instr_d[20:16];
  assign rd_d   = instr_d[15:11];
  assign simm_d = {{(XLEN-16){instr_d[15]}}, instr_d[15:0]};
  assign br_target_d = pc4_d + {{(XLEN-18){instr_d[15]}}, instr_d[15:0], 2'b00};

  core_decoder u_dec (
    .opcode_i (instr_d[31:26]),
    .shamt_i  (instr_d[10:6]),
    .funct_i  (instr_d[5:0]),
    .ctrl_o   (ctrl_d),
    .branch_o (branch_d),
    .use_rs_o (use_rs_d),
    .use_rt_o (use_rt_d)
  );

  core_regfile #(.XLEN(XLEN), .AW(RAW)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra1_i  (rs_d),
    .ra2_i  (rt_d),
    .rdbg_i (dbg_sel_i),
    .rd1_o  (rs_val_d),
    .rd2_o  (rt_val_d),
    .rdbg_o (dbg_data_o),
    .we_i   (wr_w),
    .wa_i   (dst_w),
    .wd_i   (res_w)
  );

  core_hazard #(.AW(RAW)) u_hz (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rs_i      (rs_d),
    .rt_i      (rt_d),
    .use_rs_i  (use_rs_d),
    .use_rt_i  (use_rt_d),
    .ex_we_i   (ctrl_e.reg_write),
    .ex_dst_i  (dst_e),
    .mem_we_i  (wr_m),
    .mem_dst_i (dst_m),
    .stall_o   (stall_d)
  );

  assign br_taken_d = branch_d && !stall_d && (rs_val_d == rt_val_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_e <= '0;
      a_e    <= '0;
      b_e    <= '0;
      simm_e <= '0;
      rt_e   <= '0;
      rd_e   <= '0;
    end else if (stall_d) begin
      ctrl_e <= '0;  // bubble
    end else begin
      ctrl_e <= ctrl_d;
      a_e    <= rs_val_d;
      b_e    <= rt_val_d;
      simm_e <= simm_d;
      rt_e   <= rt_d;
      rd_e   <= rd_d;
    end
  end

  // ---------------- EX ----------------
  assign src_b_e = ctrl_e.alu_src ? simm_e : b_e;
  assign dst_e   = ctrl_e.reg_dst ? rd_e : rt_e;

  always_comb begin
    case (ctrl_e.alu_op)
      ALU_SUB: alu_y_e = a_e - src_b_e;
      ALU_AND: alu_y_e = a_e & src_b_e;
      ALU_OR:  alu_y_e = a_e | src_b_e;
      ALU_SLT: alu_y_e = XLEN'($signed(a_e) < $signed(src_b_e));
      default: alu_y_e = a_e + src_b_e;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_m    <= 1'b0;
      m2r_m   <= 1'b0;
      mw_m    <= 1'b0;
      alu_m   <= '0;
      wdata_m <= '0;
      dst_m   <= '0;
    end else begin
      wr_m    <= ctrl_e.reg_write;
      m2r_m   <= ctrl_e.mem_to_reg;
      mw_m    <= ctrl_e.mem_write;
      alu_m   <= alu_y_e;
      wdata_m <= b_e;
      dst_m   <= dst_e;
    end
  end

  // ---------------- MEM ----------------
  assign dmem_addr_o  = alu_m;
  assign dmem_wdata_o = wdata_m;
  assign dmem_we_o    = mw_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_w   <= 1'b0;
      m2r_w  <= 1'b0;
      alu_w  <= '0;
      load_w <= '0;
      dst_w  <= '0;
    end else begin
      wr_w   <= wr_m;
      m2r_w  <= m2r_m;
      alu_w  <= alu_m;
      load_w <= dmem_rdata_i;
      dst_w  <= dst_m;
    end
  end

  // ---------------- WB ----------------
  assign res_w = m2r_w ? load_w : alu_w;

  a_r4_hold_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_d |=> pc_q == $past(pc_q));
  a_r4_hold_instr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_d |=> instr_d == $past(instr_d));
  a_r4_stall_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_d && $past(stall_d)) |=> !stall_d);
  a_r5_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_d |=> !ctrl_e.reg_write && !ctrl_e.mem_write);
  a_r3_seq_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_d && !br_taken_d) |=> imem_addr_o == $past(imem_addr_o) + XLEN'(4));
  a_r8_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken_d |=> imem_addr_o == $past(br_target_d));
endmodule

// File: tb/tb_core_pipe.sv
module tb_core_pipe;
  localparam int HALF_PS = 2500;  // 200 MHz with 1 ps units

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata, dbg_data;
  logic        dmem_we;
  logic [4:0]  dbg_sel = '0;

  logic [31:0] imem [64];
  logic [31:0] dmem [16];
  int          cyc, ev_n;
  int          ev_cyc [8];
  logic [31:0] ev_addr [8];
  logic [31:0] ev_data [8];
  int          total = 0, bad = 0;

  logic [31:0] rr [32];
  logic [31:0] rm [16];
  int          rstores;

  always #(HALF_PS) clk = ~clk;

  assign imem_data  = (imem_addr[31:8] == '0) ? imem[imem_addr[7:2]] : 32'h0;
  assign dmem_rdata = dmem[dmem_addr[5:2]];

  core_pipe dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .imem_addr_o  (imem_addr),
    .imem_data_i  (imem_data),
    .dmem_addr_o  (dmem_addr),
    .dmem_wdata_o (dmem_wdata),
    .dmem_we_o    (dmem_we),
    .dmem_rdata_i (dmem_rdata),
    .dbg_sel_i    (dbg_sel),
    .dbg_data_o   (dbg_data)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) dmem[i] <= 32'h1000 + i;
      cyc <= 0;
    end else begin
      if (dmem_we) dmem[dmem_addr[5:2]] <= dmem_wdata;
      cyc <= cyc + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) ev_n = 0;
    else if (dmem_we) begin
      if (ev_n < 8) begin
        ev_cyc[ev_n]  = cyc;
        ev_addr[ev_n] = dmem_addr;
        ev_data[ev_n] = dmem_wdata;
      end
      ev_n = ev_n + 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt, input int rs, input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) imem[i] = 32'h0;
  endtask

  task automatic start_prog();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_prog(input int n);
    start_prog();
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_reg(input int r, output logic [31:0] v);
    dbg_sel = r[4:0];
    #1;
    v = dbg_data;
  endtask

  // sequential reference with one delay slot
  task automatic iss();
    int idx, pend, steps;
    logic [31:0] w, a, b, simm, res, ea;
    logic [5:0]  op, fn;
    int          rs, rt, rd;
    bit          ok;
    for (int i = 0; i < 32; i++) rr[i] = '0;
    for (int i = 0; i < 16; i++) rm[i] = 32'h1000 + i;
    rstores = 0;
    idx = 0;
    pend = -1;
    steps = 0;
    while ((idx < 64 || pend >= 0) && steps < 1000) begin
      int nxt;
      w = (idx < 64) ? imem[idx] : 32'h0;
      op = w[31:26]; fn = w[5:0];
      rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
      a = rr[rs]; b = rr[rt];
      simm = {{16{w[15]}}, w[15:0]};
      ea = a + simm;
      nxt = (pend >= 0) ? pend : idx + 1;
      pend = -1;
      case (op)
        6'h00: begin
          ok = (w[10:6] == 5'd0);
          case (fn)
            6'h20: res = a + b;
            6'h22: res = a - b;
            6'h24: res = a & b;
            6'h25: res = a | b;
            6'h2A: res = {31'd0, $signed(a) < $signed(b)};
            default: begin ok = 1'b0; res = '0; end
          endcase
          if (ok && rd != 0) rr[rd] = res;
        end
        6'h08: if (rt != 0) rr[rt] = ea;
        6'h23: if (rt != 0) rr[rt] = rm[ea[5:2]];
        6'h2B: begin rm[ea[5:2]] = b; rstores++; end
        6'h04: if (a == b) pend = idx + 1 + int'($signed(w[15:0]));
        default: ;
      endcase
      idx = nxt;
      steps++;
    end
  endtask

  task automatic gen_prog(input int n);
    logic [5:0] fns [5];
    bit prev_beq;
    fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
    clear_prog();
    prev_beq = 1'b0;
    for (int i = 0; i < n; i++) begin
      int k, rs, rt, rd;
      k = int'($urandom % 9);
      if (prev_beq && k == 8) k = 0;
      rs = int'($urandom % 7);
      rt = int'($urandom % 7);
      rd = int'($urandom % 7);
      case (k)
        5: imem[i] = enc_i(6'h08, rt, rs, 16'($urandom));
        6: imem[i] = enc_i(6'h23, rt, rs, 16'(($urandom % 16) * 4));
        7: imem[i] = enc_i(6'h2B, rt, rs, 16'(($urandom % 16) * 4));
        8: imem[i] = enc_i(6'h04, rt, rs, 16'(1 + $urandom % 3));
        default: imem[i] = enc_r(fns[k], rd, rs, rt);
      endcase
      prev_beq = (k == 8);
    end
  endtask

  task automatic cmp_state(input string req);
    logic [31:0] v;
    int mism;
    mism = 0;
    for (int r = 0; r < 32; r++) begin
      rd_reg(r, v);
      if (v !== rr[r]) begin
        if (mism == 0) $display("FAIL %s reg%0d act=%0h exp=%0h", req, r, v, rr[r]);
        mism++;
      end
    end
    chk(mism == 0, "R2 registers", 32'(mism), 32'd0);
    mism = 0;
    for (int m = 0; m < 16; m++) if (dmem[m] !== rm[m]) mism++;
    chk(mism == 0, "R2 memory", 32'(mism), 32'd0);
    chk(ev_n == rstores, "R5 store count", 32'(ev_n), 32'(rstores));
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_1234));

    // R3: independent stores, one per cycle
    clear_prog();
    for (int k = 0; k < 6; k++) imem[k] = enc_i(6'h2B, 0, 0, 16'(4 * k));
    run_prog(20);
    chk(ev_n == 6, "R3 count", 32'(ev_n), 32'd6);
    for (int k = 0; k < 6; k++) chk(ev_cyc[k] == k + 3, "R3 edge", 32'(ev_cyc[k]), 32'(k + 3));

    // R4: back-to-back dependency stalls 2
    clear_prog();
    imem[0] = enc_i(6'h08, 1, 0, 16'd5);
    imem[1] = enc_i(6'h2B, 1, 0, 16'd0);
    run_prog(20);
    chk(ev_n == 1 && ev_cyc[0] == 6, "R4 distance1 edge", 32'(ev_cyc[0]), 32'd6);
    chk(ev_data[0] == 32'd5, "R4 distance1 data", ev_data[0], 32'd5);

    // R4: one instruction between stalls 1
    clear_prog();
    imem[0] = enc_i(6'h08, 1, 0, 16'd5);
    imem[1] = enc_i(6'h2B, 0, 0, 16'd4);
    imem[2] = enc_i(6'h2B, 1, 0, 16'd0);
    run_prog(20);
    chk(ev_cyc[0] == 4, "R4 distance2 first", 32'(ev_cyc[0]), 32'd4);
    chk(ev_cyc[1] == 6 && ev_data[1] == 32'd5, "R4 distance2 edge", 32'(ev_cyc[1]), 32'd6);

    // R4: two between, no stall (writeback read)
    clear_prog();
    imem[0] = enc_i(6'h08, 1, 0, 16'd5);
    imem[3] = enc_i(6'h2B, 1, 0, 16'd0);
    run_prog(20);
    chk(ev_cyc[0] == 6 && ev_data[0] == 32'd5, "R4 distance3", 32'(ev_cyc[0]), 32'd6);

    // R4: load-use
    clear_prog();
    imem[0] = enc_i(6'h23, 2, 0, 16'd8);
    imem[1] = enc_i(6'h2B, 2, 0, 16'd0);
    run_prog(20);
    chk(ev_cyc[0] == 6, "R4 load-use edge", 32'(ev_cyc[0]), 32'd6);
    chk(ev_data[0] == 32'h1002, "R4 load-use data", ev_data[0], 32'h1002);

    // R7: addi does not read rt, so matching rt causes no stall
    clear_prog();
    imem[0] = enc_i(6'h08, 1, 0, 16'd5);
    imem[1] = enc_i(6'h08, 1, 0, 16'd9);
    imem[2] = enc_i(6'h2B, 0, 0, 16'd0);
    run_prog(20);
    chk(ev_cyc[0] == 5, "R7 no false stall", 32'(ev_cyc[0]), 32'd5);
    rd_reg(1, v);
    chk(v == 32'd9, "R7 reg1", v, 32'd9);

    // R6: write to reg 0 discarded, no stall
    clear_prog();
    imem[0] = enc_i(6'h08, 0, 0, 16'd7);
    imem[1] = enc_i(6'h2B, 0, 0, 16'd0);
    run_prog(20);
    chk(ev_cyc[0] == 4, "R6 no stall edge", 32'(ev_cyc[0]), 32'd4);
    chk(ev_data[0] == 32'd0, "R6 zero data", ev_data[0], 32'd0);

    // R8: taken branch, delay slot runs, one skipped
    clear_prog();
    imem[0] = enc_i(6'h04, 0, 0, 16'd2);
    imem[1] = enc_i(6'h08, 5, 0, 16'd1);
    imem[2] = enc_i(6'h08, 6, 0, 16'd1);
    imem[3] = enc_i(6'h08, 7, 0, 16'd1);
    run_prog(20);
    rd_reg(5, v); chk(v == 32'd1, "R8 delay slot", v, 32'd1);
    rd_reg(6, v); chk(v == 32'd0, "R8 skipped", v, 32'd0);
    rd_reg(7, v); chk(v == 32'd1, "R8 target", v, 32'd1);

    // R8: not taken falls through
    clear_prog();
    imem[0] = enc_i(6'h08, 1, 0, 16'd3);
    imem[3] = enc_i(6'h04, 0, 1, 16'd2);
    imem[4] = enc_i(6'h08, 2, 0, 16'd1);
    imem[5] = enc_i(6'h08, 3, 0, 16'd1);
    run_prog(20);
    rd_reg(3, v); chk(v == 32'd1, "R8 not taken", v, 32'd1);

    // R8 + R4: branch operands pending
    clear_prog();
    imem[0] = enc_i(6'h08, 1, 0, 16'd4);
    imem[1] = enc_i(6'h08, 2, 0, 16'd4);
    imem[2] = enc_i(6'h04, 2, 1, 16'd2);
    imem[3] = enc_i(6'h2B, 0, 0, 16'd0);
    imem[4] = enc_i(6'h2B, 0, 0, 16'd4);
    imem[5] = enc_i(6'h2B, 0, 0, 16'd8);
    run_prog(24);
    chk(ev_n == 2, "R8 branch stall count", 32'(ev_n), 32'd2);
    chk(ev_cyc[0] == 8 && ev_addr[0] == 32'd0, "R8 delay slot edge", 32'(ev_cyc[0]), 32'd8);
    chk(ev_cyc[1] == 9 && ev_addr[1] == 32'd8, "R8 target edge", 32'(ev_cyc[1]), 32'd9);

    // R11: unknown opcode, nonzero shamt
    clear_prog();
    imem[0] = enc_i(6'h08, 4, 0, 16'd6);
    imem[3] = {6'h00, 5'd4, 5'd4, 5'd3, 5'd1, 6'h20};
    imem[4] = 32'hFC22_0000;
    run_prog(20);
    rd_reg(3, v); chk(v == 32'd0, "R11 shamt ignored", v, 32'd0);
    rd_reg(2, v); chk(v == 32'd0, "R11 opcode ignored", v, 32'd0);
    rd_reg(4, v); chk(v == 32'd6, "R11 prior kept", v, 32'd6);
    chk(ev_n == 0, "R11 no store", 32'(ev_n), 32'd0);

    // R10: debug shows result after edge k+5
    clear_prog();
    imem[0] = enc_i(6'h08, 1, 0, 16'd5);
    dbg_sel = 5'd1;
    start_prog();
    repeat (4) @(negedge clk);
    chk(dbg_data == 32'd0, "R10 before commit", dbg_data, 32'd0);
    @(negedge clk);
    chk(dbg_data == 32'd5, "R10 after commit", dbg_data, 32'd5);

    // R1 R2 R5: random programs against the sequential model
    for (int p = 0; p < 40; p++) begin
      gen_prog(24);
      run_prog(170);
      iss();
      cmp_state("R2");
    end

    // R9: reset state
    rst_n = 1'b0;
    #1;
    chk(imem_addr == 32'd0, "R9 fetch addr", imem_addr, 32'd0);
    chk(dmem_we == 1'b0, "R9 write enable", 32'(dmem_we), 32'd0);
    for (int r = 0; r < 32; r++) begin
      rd_reg(r, v);
      if (v != 32'd0) chk(1'b0, "R9 register", v, 32'd0);
    end
    chk(1'b1, "R9 registers zero", 32'd0, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule